// File: doc/BRIEF.md
# Edit-Distance Systolic Array

This block fills a strip of a dynamic-programming score matrix for two character strings. It uses a chain of `NPE` processing elements. Element `p` owns row `p` of the strip and holds one character of the vertical string together with that row's first-column score. The horizontal string streams in at one character per cycle. Each column brings the two scores of the row directly above the strip that sit at that column and at the column before it. Every cell takes the cheapest of three moves: diagonal (free on a character match, a substitution cost otherwise), down from the cell above (insertion cost) and right from the cell to the left (deletion cost). All three costs are runtime inputs.

Each element keeps its last result in a local register, which becomes its left-hand neighbour for the next column. The value that register held before the update goes down the chain as the diagonal input of the element below. A column therefore reaches element `p` one cycle after element `p-1`. Only the bottom row of the strip leaves the block. A host splits a long vertical string into strips and feeds each strip's output row back as the next strip's top row.

A four-state controller sequences each strip. **IDLE** moves to **RUN** on `start` and captures the per-row characters and first-column scores on that edge. **RUN** accepts columns and moves to **DRAIN** when a column marked last is accepted. **DRAIN** moves to **DONE** once that last column is held in the final element. **DONE** lasts one cycle and always returns to **IDLE**.

Top module: `ed_systolic`

## Requirements
- R1: When the streamed character equals an element's row character, the diagonal candidate is the diagonal score unchanged. Otherwise it is the diagonal score plus `sub_cost`.
- R2: Each cell result is the minimum of three candidates: the diagonal candidate, the score above plus `ins_cost`, and the score to the left plus `del_cost`.
- R3: For the first column, the left score of element `p` is `col0[p*16 +: 16]`. For every later column it is that element's own result for the previous column. The diagonal score of element `p>0` is the left score that element `p-1` used for the same column. Element 0 takes its above and diagonal scores from `in_north` and `in_nw`.
- R4: `t_chars[p*8 +: 8]` and `col0` are captured only on a `start` seen in IDLE. A `start` in any other state changes no result.
- R5: Each column accepted in RUN produces exactly one bottom-row score, in column order. That score appears on `out_score` with `out_valid` high `NPE+1` cycles after the accepting edge. `out_last` is high only together with `out_valid`, on the column that was marked last. Idle cycles between columns are allowed.
- R6: Every cost addition saturates at 65535 instead of wrapping.
- R7: A column presented while the controller is not in RUN is dropped and produces no output.
- R8: `strip_done` is a one-cycle pulse raised in the same cycle as the output of the last column.
- R9: While reset is asserted and right after it is released, `out_valid`, `out_last` and `strip_done` are low.
- R10: The controller is in IDLE the cycle after `strip_done`, and a `start` in that cycle begins a new strip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a strip (honoured in IDLE only) |
| t_chars | input | NPE*8 | Row characters, element p in bits p*8 +: 8 |
| col0 | input | NPE*16 | First-column scores, element p in bits p*16 +: 16 |
| ins_cost | input | 16 | Cost added to the score above |
| del_cost | input | 16 | Cost added to the score on the left |
| sub_cost | input | 16 | Cost added to the diagonal on a character mismatch |
| in_valid | input | 1 | A column is presented |
| in_last | input | 1 | The presented column is the strip's last |
| in_chr | input | 8 | Horizontal-string character for the column |
| in_north | input | 16 | Top-row score at this column |
| in_nw | input | 16 | Top-row score at the previous column |
| out_valid | output | 1 | Bottom-row score is valid |
| out_last | output | 1 | Score belongs to the last column |
| out_score | output | 16 | Bottom-row score |
| strip_done | output | 1 | Strip finished pulse |

## Verification
A stale or misrouted left register shows as a wrong bottom-row score at the very next column. It surfaces `NPE+1` cycles after that column was accepted, because every row's error propagates downward into the emitted row. A row character reloaded mid-strip corrupts every later output of that strip. A controller stuck in RUN or DRAIN shows as a missing `strip_done` and a dropped next `start`. A controller that accepts columns outside RUN shows as extra outputs within `NPE+1` cycles.

// File: rtl/ed_sys_pkg.sv
package ed_sys_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } strip_state_e;

endpackage

// File: rtl/ed_cell.sv
module ed_cell #(
    parameter int CW = 8,
    parameter int SW = 16
) (
    input  logic [CW-1:0] row_chr,
    input  logic [CW-1:0] col_chr,
    input  logic [SW-1:0] north,
    input  logic [SW-1:0] nw,
    input  logic [SW-1:0] west,
    input  logic [SW-1:0] ins_cost,
    input  logic [SW-1:0] del_cost,
    input  logic [SW-1:0] sub_cost,
    output logic [SW-1:0] result
);
    localparam logic [SW-1:0] SAT_MAX = '1;

    function automatic logic [SW-1:0] sat_add(input logic [SW-1:0] a, input logic [SW-1:0] b);
        logic [SW:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return sum[SW] ? SAT_MAX : sum[SW-1:0];
    endfunction

    logic [SW-1:0] cand_diag;
    logic [SW-1:0] cand_down;
    logic [SW-1:0] cand_right;
    logic [SW-1:0] best_dd;

    always_comb begin
        cand_diag  = (row_chr == col_chr) ? nw : sat_add(nw, sub_cost);
        cand_down  = sat_add(north, ins_cost);
        cand_right = sat_add(west, del_cost);
        best_dd    = (cand_down < cand_diag) ? cand_down : cand_diag;
        result     = (cand_right < best_dd) ? cand_right : best_dd;
    end
endmodule

// File: rtl/ed_pe.sv
module ed_pe #(
    parameter int CW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] t_in,
    input  logic [SW-1:0] w_init,
    input  logic          up_vld,
    input  logic          up_last,
    input  logic [CW-1:0] up_chr,
    input  logic [SW-1:0] up_north,
    input  logic [SW-1:0] up_nw,
    input  logic [SW-1:0] ins_cost,
    input  logic [SW-1:0] del_cost,
    input  logic [SW-1:0] sub_cost,
    output logic          dn_vld,
    output logic          dn_last,
    output logic [CW-1:0] dn_chr,
    output logic [SW-1:0] dn_val,
    output logic [SW-1:0] dn_nw,
    output logic [CW-1:0] t_q_o
);
    logic [CW-1:0] t_q;
    logic [SW-1:0] west_q;
    logic          vld_q;
    logic          last_q;
    logic [CW-1:0] chr_q;
    logic [SW-1:0] north_q;
    logic [SW-1:0] nw_q;
    logic [SW-1:0] cell_val;

    ed_cell #(.CW(CW), .SW(SW)) cell_i (
        .row_chr  (t_q),
        .col_chr  (chr_q),
        .north    (north_q),
        .nw       (nw_q),
        .west     (west_q),
        .ins_cost (ins_cost),
        .del_cost (del_cost),
        .sub_cost (sub_cost),
        .result   (cell_val)
    );

    // Row character and left-neighbour feedback register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q    <= '0;
            west_q <= '0;
        end else if (load) begin
            t_q    <= t_in;
            west_q <= w_init;
        end else if (vld_q) begin
            west_q <= cell_val;
        end
    end

    // Column skew register: one cycle per element.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            last_q  <= 1'b0;
            chr_q   <= '0;
            north_q <= '0;
            nw_q    <= '0;
        end else begin
            vld_q <= up_vld;
            if (up_vld) begin
                last_q  <= up_last;
                chr_q   <= up_chr;
                north_q <= up_north;
                nw_q    <= up_nw;
            end
        end
    end

    assign dn_vld  = vld_q;
    assign dn_last = last_q;
    assign dn_chr  = chr_q;
    assign dn_val  = cell_val;
    assign dn_nw   = west_q;
    assign t_q_o   = t_q;
endmodule

// File: rtl/ed_strip_ctrl.sv
module ed_strip_ctrl
    import ed_sys_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic in_last,
    input  logic tail_last,
    output logic load_strip,
    output logic accept,
    output logic idle,
    output logic strip_done
);
    strip_state_e state_q;
    strip_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                state_d = ST_RUN;
            ST_RUN:   if (in_valid && in_last)  state_d = ST_DRAIN;
            ST_DRAIN: if (tail_last)            state_d = ST_DONE;
            ST_DONE:                            state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_strip = 1'b0;
        accept     = 1'b0;
        idle       = 1'b0;
        strip_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle       = 1'b1;
                load_strip = start;
            end
            ST_RUN:   accept     = 1'b1;
            ST_DRAIN: ;
            ST_DONE:  strip_done = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/ed_systolic.sv
module ed_systolic #(
    parameter int NPE = 4,
    parameter int CW  = 8,
    parameter int SW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NPE*CW-1:0] t_chars,
    input  logic [NPE*SW-1:0] col0,
    input  logic [SW-1:0]     ins_cost,
    input  logic [SW-1:0]     del_cost,
    input  logic [SW-1:0]     sub_cost,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [CW-1:0]     in_chr,
    input  logic [SW-1:0]     in_north,
    input  logic [SW-1:0]     in_nw,
    output logic              out_valid,
    output logic              out_last,
    output logic [SW-1:0]     out_score,
    output logic              strip_done
);
    localparam int LASTPE = NPE - 1;

    logic load_strip;
    logic accept;
    logic idle;
    logic tail_last;
    logic pe0_vld;
    logic [NPE*CW-1:0] t_cur;

    logic          o_vld  [NPE];
    logic          o_last [NPE];
    logic [CW-1:0] o_chr  [NPE];
    logic [SW-1:0] o_val  [NPE];
    logic [SW-1:0] o_nw   [NPE];

    ed_strip_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .tail_last  (tail_last),
        .load_strip (load_strip),
        .accept     (accept),
        .idle       (idle),
        .strip_done (strip_done)
    );

    generate
        for (genvar p = 0; p < NPE; p++) begin : g_pe
            logic          u_vld;
            logic          u_last;
            logic [CW-1:0] u_chr;
            logic [SW-1:0] u_north;
            logic [SW-1:0] u_nw;
            if (p == 0) begin : g_head
                assign u_vld   = in_valid && accept;
                assign u_last  = in_last;
                assign u_chr   = in_chr;
                assign u_north = in_north;
                assign u_nw    = in_nw;
            end else begin : g_link
                assign u_vld   = o_vld[p-1];
                assign u_last  = o_last[p-1];
                assign u_chr   = o_chr[p-1];
                assign u_north = o_val[p-1];
                assign u_nw    = o_nw[p-1];
            end
            ed_pe #(.CW(CW), .SW(SW)) pe_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load_strip),
                .t_in     (t_chars[p*CW +: CW]),
                .w_init   (col0[p*SW +: SW]),
                .up_vld   (u_vld),
                .up_last  (u_last),
                .up_chr   (u_chr),
                .up_north (u_north),
                .up_nw    (u_nw),
                .ins_cost (ins_cost),
                .del_cost (del_cost),
                .sub_cost (sub_cost),
                .dn_vld   (o_vld[p]),
                .dn_last  (o_last[p]),
                .dn_chr   (o_chr[p]),
                .dn_val   (o_val[p]),
                .dn_nw    (o_nw[p]),
                .t_q_o    (t_cur[p*CW +: CW])
            );
        end
    endgenerate

    assign tail_last = o_vld[LASTPE] && o_last[LASTPE];
    assign pe0_vld   = o_vld[0];

    logic tail_unused;
    assign tail_unused = ^{o_chr[LASTPE], o_nw[LASTPE]};

    // Bottom-row output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_score <= '0;
        end else begin
            out_valid <= o_vld[LASTPE];
            out_last  <= tail_last;
            if (o_vld[LASTPE]) out_score <= o_val[LASTPE];
        end
    end
endmodule

// File: rtl/ed_systolic_chk.sv
module ed_systolic_chk #(
    parameter int NPE = 4,
    parameter int CW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              accept,
    input logic              idle,
    input logic              pe0_vld,
    input logic              out_valid,
    input logic              out_last,
    input logic              strip_done,
    input logic [NPE*CW-1:0] t_cur
);
    assert_done_with_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strip_done |-> (out_valid && out_last));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strip_done |=> !strip_done);

    assert_done_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strip_done |=> idle);

    assert_drop_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !accept) |=> !pe0_vld);

    assert_take_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && accept) |=> pe0_vld);

    assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_rowchar_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(t_cur));
endmodule

bind ed_systolic ed_systolic_chk #(.NPE(NPE), .CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .accept     (accept),
    .idle       (idle),
    .pe0_vld    (pe0_vld),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .strip_done (strip_done),
    .t_cur      (t_cur)
);

// File: tb/ed_systolic_tb_top.sv
`timescale 1ns/1ps
module ed_systolic_tb_top;
    localparam int NPE  = 4;
    localparam int CW   = 8;
    localparam int SW   = 16;
    localparam int MAXL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              start = 1'b0;
    logic [NPE*CW-1:0] t_chars = '0;
    logic [NPE*SW-1:0] col0 = '0;
    logic [SW-1:0]     ins_cost = '0, del_cost = '0, sub_cost = '0;
    logic              in_valid = 1'b0, in_last = 1'b0;
    logic [CW-1:0]     in_chr = '0;
    logic [SW-1:0]     in_north = '0, in_nw = '0;
    logic              out_valid, out_last, strip_done;
    logic [SW-1:0]     out_score;

    ed_systolic #(.NPE(NPE), .CW(CW), .SW(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .t_chars(t_chars), .col0(col0),
        .ins_cost(ins_cost), .del_cost(del_cost), .sub_cost(sub_cost),
        .in_valid(in_valid), .in_last(in_last), .in_chr(in_chr),
        .in_north(in_north), .in_nw(in_nw), .out_valid(out_valid),
        .out_last(out_last), .out_score(out_score), .strip_done(strip_done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    int unsigned t_arr [NPE];
    int unsigned w_arr [NPE];
    int unsigned s_str [MAXL+1];
    int unsigned n_row [MAXL+1];
    int unsigned exp_row [MAXL+1];

    int unsigned exp_sc_q [$];
    bit          exp_last_q [$];
    int          exp_due_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int unsigned rnd(input int unsigned m);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed % m;
    endfunction

    function automatic int unsigned sat(input int unsigned a, input int unsigned b);
        int unsigned s;
        s = a + b;
        return (s > 65535) ? 65535 : s;
    endfunction

    // Reference model of the strip (R1, R2, R3, R6).
    task automatic model(input int L);
        int unsigned prev [MAXL+1];
        int unsigned cur  [MAXL+1];
        for (int j = 0; j <= L; j++) prev[j] = n_row[j];
        for (int p = 0; p < NPE; p++) begin
            cur[0] = w_arr[p];
            for (int j = 1; j <= L; j++) begin
                int unsigned d, n, w, m;
                d = (t_arr[p] == s_str[j]) ? prev[j-1] : sat(prev[j-1], sub_cost);
                n = sat(prev[j], ins_cost);
                w = sat(cur[j-1], del_cost);
                m = (n < d) ? n : d;
                cur[j] = (w < m) ? w : m;
            end
            for (int j = 0; j <= L; j++) prev[j] = cur[j];
        end
        for (int j = 0; j <= L; j++) exp_row[j] = prev[j];
    endtask

    // Monitor: compares results as they leave the design.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (exp_sc_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected out_valid", 1, 0);
                end else begin
                    int unsigned es;
                    bit el;
                    int ed;
                    es = exp_sc_q.pop_front();
                    el = exp_last_q.pop_front();
                    ed = exp_due_q.pop_front();
                    chk(out_score == SW'(es), "R1/R2/R3/R6", "bottom-row score", out_score, es);
                    chk(out_last == el, "R5", "out_last", out_last, el);
                    chk(cyc == ed, "R5", "output cycle", cyc, ed);
                end
            end
            if (strip_done || (out_valid && out_last))
                chk(strip_done == (out_valid && out_last), "R8", "done with last output",
                    strip_done, out_valid && out_last);
        end
    end

    // Driver: runs one strip and pushes the expected bottom row.
    task automatic run_strip(input int L, input bit gaps, input bit poke_start);
        model(L);
        for (int p = 0; p < NPE; p++) begin
            t_chars[p*CW +: CW] = CW'(t_arr[p]);
            col0[p*SW +: SW]    = SW'(w_arr[p]);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 1; j <= L; j++) begin
            if (gaps && (j % 3 == 0)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_last  = (j == L);
            in_chr   = CW'(s_str[j]);
            in_north = SW'(n_row[j]);
            in_nw    = SW'(n_row[j-1]);
            exp_sc_q.push_back(exp_row[j]);
            exp_last_q.push_back(j == L);
            exp_due_q.push_back(cyc + 1 + NPE);
            if (poke_start && j == 2) begin
                start   = 1'b1;   // R4: must not reload mid-strip
                t_chars = ~t_chars;
                col0    = '1;
            end
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (strip_done !== 1'b1) @(negedge clk);
        @(negedge clk);
        chk(exp_sc_q.size() == 0, "R5", "outputs pending after done", exp_sc_q.size(), 0);
        chk(strip_done == 1'b0, "R8", "done pulse length", strip_done, 0);
    endtask

    task automatic fill_random(input int L, input int unsigned alpha, input int unsigned nmax,
                               input int unsigned base);
        for (int p = 0; p < NPE; p++) begin
            t_arr[p] = 97 + rnd(alpha);
            w_arr[p] = base + rnd(nmax);
        end
        for (int j = 0; j <= L; j++) begin
            s_str[j] = 97 + rnd(alpha);
            n_row[j] = base + rnd(nmax);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual=hung expected=strip completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(out_valid == 0 && out_last == 0 && strip_done == 0, "R9", "outputs in reset",
            {out_valid, out_last, strip_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && out_last == 0 && strip_done == 0, "R9", "outputs after reset",
            {out_valid, out_last, strip_done}, 0);

        // R7: columns while idle are dropped.
        in_valid = 1'b1;
        in_last  = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        for (int k = 0; k < NPE + 3; k++) begin
            chk(out_valid == 0 && strip_done == 0, "R7", "no output for idle columns",
                {out_valid, strip_done}, 0);
            @(negedge clk);
        end

        // Strip 1: unit costs, classic edit distance (R1, R2, R3).
        ins_cost = 1; del_cost = 1; sub_cost = 1;
        t_arr[0] = 107; t_arr[1] = 105; t_arr[2] = 116; t_arr[3] = 116;
        for (int p = 0; p < NPE; p++) w_arr[p] = p + 1;
        s_str[1] = 115; s_str[2] = 105; s_str[3] = 116; s_str[4] = 116;
        s_str[5] = 105; s_str[6] = 110; s_str[7] = 103;
        for (int j = 0; j <= 7; j++) n_row[j] = j;
        s_str[0] = 0;
        run_strip(7, 1'b0, 1'b0);

        // Strip 2: unequal costs, gaps between columns (R2, R5), back to back (R10).
        ins_cost = 2; del_cost = 3; sub_cost = 5;
        fill_random(12, 4, 20, 0);
        run_strip(12, 1'b1, 1'b0);

        // Strip 3: start pulsed mid-strip is ignored (R4).
        ins_cost = 1; del_cost = 2; sub_cost = 1;
        fill_random(9, 3, 10, 0);
        run_strip(9, 1'b0, 1'b1);

        // Strip 4: saturation of every addition (R6).
        ins_cost = 16'hFFF0; del_cost = 16'hFFF0; sub_cost = 16'hFFF0;
        fill_random(6, 2, 200, 16'hFE00);
        for (int p = 0; p < NPE; p++) t_arr[p] = 200;
        run_strip(6, 1'b0, 1'b0);

        // Strip 5: single column strip, last on first column (R5, R8, R10).
        ins_cost = 3; del_cost = 1; sub_cost = 2;
        fill_random(1, 3, 8, 0);
        run_strip(1, 1'b0, 1'b0);

        // Strip 6: longest strip, mixed costs, with gaps (R1, R2, R3).
        ins_cost = 1; del_cost = 1; sub_cost = 3;
        fill_random(MAXL, 5, 30, 0);
        run_strip(MAXL, 1'b1, 1'b0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule